// File: doc/BRIEF.md
# Command-Stream Predicate Evaluation Unit

This unit sits beside a command-stream parser and decides whether draw commands are allowed to run. It holds two 64-bit operand registers, a 64-bit reference register and a single predicate bit. Software or an upstream engine fills the operands through a simple 32-bit register port, one half at a time. Operand values arrive already resolved, so no memory traffic is involved.

When the parser presents a predicate command dword, the unit evaluates a comparison of the operands. It then loads that result, plain or inverted, or keeps the old bit. Finally it merges the loaded value into the predicate bit with a set, AND, OR or XOR step, all in one clock. When the parser presents the first dword of a draw, the unit answers in the same cycle. The draw either goes ahead or is skipped, and it is skipped only if the draw carries its own predicate-enable flag while the bit is 0.

Top module: `cs_predicate_unit`

## Requirements
- R1: After reset, every operand and reference half reads 0 and the predicate-result location reads 1, so draws proceed by default.
- R2: The register port maps six 32-bit halves, each taking the low word at the lower address. Operand A is at 0x2400/0x2404, operand B at 0x2408/0x240C and the reference at 0x2410/0x2414. A write with `regWrEn` updates the half at the next clock. Reads are combinational. 0x2418 reads the predicate bit in bit 0 with zeros above, and writes to it are ignored. Any other address reads 0.
- R3: A predicate command is a dword presented with `cmdValid` high and `cmdIsDraw` low, with bits 31:29 equal to 0 and bits 28:23 equal to 0x0C. Any other dword, including a draw dword that happens to hold those bits, leaves the predicate bit unchanged.
- R4: The compare field, bits 1:0, selects the result: 0 is always true, 1 is always false, and 2 is true when operand A equals operand B.
- R5: Compare code 3 is true when (A − B) modulo 2^64 equals the reference register.
- R6: The load field, bits 7:6, works as follows: 2 loads the compare result and 3 loads its inverse. Codes 0 and 1 leave the predicate bit unchanged whatever the combine field holds.
- R7: The combine field, bits 5:3, merges the loaded value L with the current bit P: 0 gives L, 1 gives P AND L, 2 gives P OR L, 3 gives P XOR L, and codes 4 to 7 give L.
- R8: A predicate command takes effect at the clock edge that accepts it. A draw or a result read in the very next cycle sees the new bit.
- R9: A draw is a dword with `cmdValid` and `cmdIsDraw` high, and bit 8 is its predicate-enable flag. In the same cycle exactly one of `drawIssue` and `drawSkip` goes high. `drawSkip` is chosen only when the flag is 1 and the predicate bit is 0. Neither output is high without a draw.
- R10: When a register write and a predicate command fall in the same cycle, the command evaluates the operand values held before that write, and the write still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command dword is presented this cycle |
| cmdIsDraw | input | 1 | The presented dword is the first dword of a draw |
| cmdDword | input | 32 | Command dword |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 16 | Byte address for register read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data at `regAddr` |
| drawIssue | output | 1 | Presented draw proceeds |
| drawSkip | output | 1 | Presented draw is suppressed |
| predState | output | 1 | Current predicate bit |

## Verification
The two functions that can share a cycle are an operand write on the register port and a predicate command on the command port. The bench provokes this by writing operand B in the same cycle as an equality command. It does this once with a write that would make the operands equal, and once with a write that would make them differ. The expected bit follows the pre-write values. A read in the following cycle confirms that the write still landed. A reference model is compared on every clock, and each case is judged by the predicate bit and by the answer to a flagged draw issued right after it.

// File: rtl/cs_pred_pkg.sv
package cs_pred_pkg;

  localparam int unsigned NUM_HALVES = 6;
  localparam int unsigned SEL_W      = 3;

  typedef enum logic [1:0] {
    CMP_TRUE  = 2'd0,
    CMP_FALSE = 2'd1,
    CMP_EQUAL = 2'd2,
    CMP_DELTA = 2'd3
  } cmpOp_e;

  typedef enum logic [1:0] {
    LD_KEEP    = 2'd0,
    LD_RSVD    = 2'd1,
    LD_LOAD    = 2'd2,
    LD_LOADINV = 2'd3
  } loadOp_e;

  typedef enum logic [2:0] {
    CB_SET = 3'd0,
    CB_AND = 3'd1,
    CB_OR  = 3'd2,
    CB_XOR = 3'd3
  } combOp_e;

  // Read selector values beyond the halves
  localparam logic [SEL_W-1:0] SEL_RESULT = 3'd6;
  localparam logic [SEL_W-1:0] SEL_NONE   = 3'd7;

  typedef struct packed {
    logic [NUM_HALVES-1:0] halfWr;
    logic [SEL_W-1:0]      rdSel;
    logic                  predUpd;
    cmpOp_e                cmpOp;
    loadOp_e               loadOp;
    logic [2:0]            combOp;
    logic                  drawReq;
    logic                  drawPredEn;
  } ctrlStrobes_t;

endpackage

// File: rtl/cs_pred_ctrl.sv
module cs_pred_ctrl
  import cs_pred_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CMD_W     = 32,
  parameter logic [15:0] BASE_ADDR = 16'h2400,
  parameter logic [5:0]  PRED_OPC  = 6'h0C,
  parameter int unsigned DRAW_EN_BIT = 8
) (
  input  logic              cmdValid,
  input  logic              cmdIsDraw,
  input  logic [CMD_W-1:0]  cmdDword,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes
);

  localparam int unsigned NUM_SLOTS = NUM_HALVES + 1;
  localparam int unsigned SPAN      = NUM_SLOTS * 4;

  logic [ADDR_W-1:0] offs;
  logic              inWindow;
  logic [SEL_W-1:0]  slot;
  logic              isMiType;
  logic              isPredCmd;

  assign offs     = regAddr - ADDR_W'(BASE_ADDR);
  assign inWindow = (regAddr >= ADDR_W'(BASE_ADDR)) &&
                    (offs < ADDR_W'(SPAN)) && (offs[1:0] == 2'b00);
  assign slot     = inWindow ? offs[SEL_W+1:2] : SEL_NONE;

  assign isMiType  = (cmdDword[31:29] == 3'b000);
  assign isPredCmd = cmdValid && !cmdIsDraw && isMiType &&
                     (cmdDword[28:23] == PRED_OPC);

  for (genvar g = 0; g < NUM_HALVES; g++) begin : gen_wr
    assign strobes.halfWr[g] = regWrEn && (slot == SEL_W'(g));
  end

  assign strobes.rdSel      = slot;
  assign strobes.predUpd    = isPredCmd;
  assign strobes.cmpOp      = cmpOp_e'(cmdDword[1:0]);
  assign strobes.combOp     = cmdDword[5:3];
  assign strobes.loadOp     = loadOp_e'(cmdDword[7:6]);
  assign strobes.drawReq    = cmdValid && cmdIsDraw;
  assign strobes.drawPredEn = cmdDword[DRAW_EN_BIT];

endmodule

// File: rtl/cs_pred_datapath.sv
module cs_pred_datapath
  import cs_pred_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData,
  output logic              drawIssue,
  output logic              drawSkip,
  output logic              predBit
);

  localparam int unsigned FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] halfReg [NUM_HALVES];
  logic [FULL_W-1:0] opA, opB, refVal, delta;
  logic cmpRes, loadVal, mergeVal, predNext;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : gen_half
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 halfReg[g] <= '0;
      else if (strobes.halfWr[g]) halfReg[g] <= wrData;
    end
  end

  assign opA    = {halfReg[1], halfReg[0]};
  assign opB    = {halfReg[3], halfReg[2]};
  assign refVal = {halfReg[5], halfReg[4]};
  assign delta  = opA - opB;

  always_comb begin
    unique case (strobes.cmpOp)
      CMP_TRUE:  cmpRes = 1'b1;
      CMP_FALSE: cmpRes = 1'b0;
      CMP_EQUAL: cmpRes = (opA == opB);
      CMP_DELTA: cmpRes = (delta == refVal);
      default:   cmpRes = 1'b0;
    endcase
  end

  assign loadVal = (strobes.loadOp == LD_LOADINV) ? ~cmpRes : cmpRes;

  always_comb begin
    case (strobes.combOp)
      3'(CB_AND): mergeVal = predBit & loadVal;
      3'(CB_OR):  mergeVal = predBit | loadVal;
      3'(CB_XOR): mergeVal = predBit ^ loadVal;
      default:    mergeVal = loadVal;
    endcase
  end

  // Load codes 0 and 1 keep the bit; only codes 2 and 3 reach the merge
  assign predNext = (strobes.predUpd && strobes.loadOp[1]) ? mergeVal : predBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) predBit <= 1'b1;
    else       predBit <= predNext;
  end

  always_comb begin
    rdData = '0;
    if (strobes.rdSel == SEL_RESULT) begin
      rdData = HALF_W'(predBit);
    end else begin
      for (int i = 0; i < NUM_HALVES; i++) begin
        if (strobes.rdSel == SEL_W'(i)) rdData = halfReg[i];
      end
    end
  end

  assign drawIssue = strobes.drawReq && (!strobes.drawPredEn || predBit);
  assign drawSkip  = strobes.drawReq && strobes.drawPredEn && !predBit;

  assert_draw_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({drawIssue, drawSkip}));

  assert_no_draw_no_answer_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.drawReq |-> !(drawIssue || drawSkip));

  assert_keep_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.predUpd && !strobes.loadOp[1]) |=> $stable(predBit));

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.predUpd |=> $stable(predBit));

endmodule

// File: rtl/cs_predicate_unit.sv
module cs_predicate_unit
  import cs_pred_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned HALF_W    = 32,
  parameter logic [15:0] BASE_ADDR = 16'h2400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdIsDraw,
  input  logic [HALF_W-1:0] cmdDword,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [HALF_W-1:0] regWrData,
  output logic [HALF_W-1:0] regRdData,
  output logic              drawIssue,
  output logic              drawSkip,
  output logic              predState
);

  ctrlStrobes_t strobes;

  cs_pred_ctrl #(
    .ADDR_W   (ADDR_W),
    .CMD_W    (HALF_W),
    .BASE_ADDR(BASE_ADDR)
  ) i_ctrl (
    .cmdValid (cmdValid),
    .cmdIsDraw(cmdIsDraw),
    .cmdDword (cmdDword),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .strobes  (strobes)
  );

  cs_pred_datapath #(
    .HALF_W(HALF_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .drawIssue(drawIssue),
    .drawSkip (drawSkip),
    .predBit  (predState)
  );

  // Port-level view of a "load compare-true, replace" command
  logic setTrueCmd;
  assign setTrueCmd = cmdValid && !cmdIsDraw && (cmdDword[31:23] == 9'h00C) &&
                      (cmdDword[7:0] == 8'h80);

  assert_set_true_R7: assert property (@(posedge clk) disable iff (!rstN)
    setTrueCmd |=> predState);

  assert_unflagged_draw_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIsDraw && !cmdDword[8]) |-> drawIssue);

  assert_result_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == (BASE_ADDR + 16'h18)) |-> (regRdData == HALF_W'(predState)));

endmodule

// File: tb/test_cs_predicate_unit.sv
module test_cs_predicate_unit;

  localparam int PERIOD = 10;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdIsDraw = 1'b0, regWrEn = 1'b0;
  logic [31:0] cmdDword = '0, regWrData = '0;
  logic [15:0] regAddr = '0;
  logic [31:0] regRdData;
  logic        drawIssue, drawSkip, predState;

  int nVec = 0;
  int nBad = 0;

  // Reference state
  longint unsigned mA, mB, mRef;
  bit mP;

  always #(PERIOD/2) clk = ~clk;

  cs_predicate_unit i_cs_predicate_unit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsDraw(cmdIsDraw),
    .cmdDword(cmdDword), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .drawIssue(drawIssue),
    .drawSkip(drawSkip), .predState(predState)
  );

  function automatic logic [31:0] mRead(input logic [15:0] a);
    case (a)
      16'h2400: return mA[31:0];
      16'h2404: return mA[63:32];
      16'h2408: return mB[31:0];
      16'h240C: return mB[63:32];
      16'h2410: return mRef[31:0];
      16'h2414: return mRef[63:32];
      16'h2418: return {31'b0, mP};
      default:  return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] predCmd(input int ld, input int cb, input int cp);
    return {3'b000, 6'h0C, 14'h0, 1'b0, 2'(ld), 3'(cb), 1'b0, 2'(cp)};
  endfunction

  task automatic modelUpdate();
    bit isPred, c, l, v;
    longint unsigned d;
    isPred = cmdValid && !cmdIsDraw && cmdDword[31:29] == 3'b000 && cmdDword[28:23] == 6'h0C;
    if (isPred && cmdDword[7]) begin
      d = mA - mB;
      case (cmdDword[1:0])
        2'd0: c = 1; 2'd1: c = 0;
        2'd2: c = (mA == mB);
        default: c = (d == mRef);
      endcase
      l = cmdDword[6] ? !c : c;
      case (cmdDword[5:3])
        3'd1: v = mP & l; 3'd2: v = mP | l; 3'd3: v = mP ^ l;
        default: v = l;
      endcase
      mP = v;
    end
    if (regWrEn) begin
      case (regAddr)
        16'h2400: mA[31:0]    = regWrData;
        16'h2404: mA[63:32]   = regWrData;
        16'h2408: mB[31:0]    = regWrData;
        16'h240C: mB[63:32]   = regWrData;
        16'h2410: mRef[31:0]  = regWrData;
        16'h2414: mRef[63:32] = regWrData;
        default: ;
      endcase
    end
  endtask

  task automatic step(input bit v, input bit dr, input logic [31:0] dw,
                      input bit we, input logic [15:0] a, input logic [31:0] wd,
                      input string tag);
    bit expIssue, expSkip, bad;
    logic [31:0] expRd;
    cmdValid = v; cmdIsDraw = dr; cmdDword = dw;
    regWrEn = we; regAddr = a; regWrData = wd;
    #(PERIOD/4);
    expRd    = mRead(a);
    expIssue = v && dr && (!dw[8] || mP);
    expSkip  = v && dr && dw[8] && !mP;
    bad = 0;
    nVec++;
    if (regRdData !== expRd) begin
      $display("FAIL %s read @%h: actual %h expected %h", tag, a, regRdData, expRd); bad = 1;
    end
    if (drawIssue !== expIssue || drawSkip !== expSkip) begin
      $display("FAIL %s draw: actual issue=%b skip=%b expected issue=%b skip=%b",
               tag, drawIssue, drawSkip, expIssue, expSkip); bad = 1;
    end
    if (predState !== mP) begin
      $display("FAIL %s predicate: actual %b expected %b", tag, predState, mP); bad = 1;
    end
    if (bad) nBad++;
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
    step(0, 0, 0, 1, a, d, tag);
  endtask
  task automatic pc(input int ld, input int cb, input int cp, input string tag);
    step(1, 0, predCmd(ld, cb, cp), 0, 16'h2418, 0, tag);
  endtask
  task automatic drawF(input bit en, input string tag);
    step(1, 1, {23'h0, en, 8'h00}, 0, 16'h2418, 0, tag);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin : main
    mA = 0; mB = 0; mRef = 0; mP = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 16'(16'h2400 + 4*i), 0, "R1");

    // R2: writes, readback, read-only result, unmapped
    wr(16'h2400, 32'h1111_0001, "R2"); wr(16'h2404, 32'hA5A5_0002, "R2");
    wr(16'h2408, 32'h1111_0001, "R2"); wr(16'h240C, 32'hA5A5_0002, "R2");
    wr(16'h2410, 32'hDEAD_BEEF, "R2"); wr(16'h2414, 32'h0BAD_F00D, "R2");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 16'(16'h2400 + 4*i), 0, "R2");
    wr(16'h2418, 32'h0, "R2");
    step(0, 0, 0, 0, 16'h2418, 0, "R2");
    wr(16'h241C, 32'hFFFF_FFFF, "R2");
    step(0, 0, 0, 0, 16'h241C, 0, "R2");
    step(0, 0, 0, 0, 16'h2402, 0, "R2");

    // R4: compare codes with replace
    pc(2, 0, 1, "R4"); drawF(1, "R4");
    pc(2, 0, 0, "R4"); drawF(1, "R4");
    pc(2, 0, 1, "R4");
    pc(2, 0, 2, "R4"); drawF(1, "R4");
    wr(16'h2408, 32'h1111_0000, "R4");
    pc(2, 0, 2, "R4"); drawF(1, "R4");

    // R5: delta compare with 64-bit wrap
    wr(16'h2400, 32'd5, "R5"); wr(16'h2404, 32'd0, "R5");
    wr(16'h2408, 32'd7, "R5"); wr(16'h240C, 32'd0, "R5");
    wr(16'h2410, 32'hFFFF_FFFE, "R5"); wr(16'h2414, 32'hFFFF_FFFF, "R5");
    pc(2, 0, 3, "R5"); drawF(1, "R5");
    wr(16'h2410, 32'hFFFF_FFFD, "R5");
    pc(2, 0, 3, "R5"); drawF(1, "R5");

    // R6: load codes
    pc(3, 0, 1, "R6"); step(0, 0, 0, 0, 16'h2418, 0, "R6");
    pc(0, 0, 1, "R6"); pc(0, 3, 0, "R6"); pc(1, 3, 0, "R6"); pc(1, 0, 1, "R6");
    step(0, 0, 0, 0, 16'h2418, 0, "R6");
    pc(3, 0, 0, "R6"); step(0, 0, 0, 0, 16'h2418, 0, "R6");

    // R7: combine codes
    pc(2, 1, 0, "R7"); pc(2, 1, 1, "R7");
    pc(2, 2, 1, "R7"); pc(2, 2, 0, "R7");
    pc(2, 3, 0, "R7"); pc(2, 3, 0, "R7"); pc(2, 3, 1, "R7");
    pc(2, 5, 1, "R7"); pc(2, 7, 0, "R7"); pc(2, 4, 1, "R7");
    step(0, 0, 0, 0, 16'h2418, 0, "R7");

    // R3: non-predicate dwords leave the bit
    step(1, 0, {3'b000, 6'h0D, 15'h0, 8'h80}, 0, 16'h2418, 0, "R3");
    step(1, 0, {3'b011, 6'h0C, 15'h0, 8'h80}, 0, 16'h2418, 0, "R3");
    step(1, 1, predCmd(2, 0, 0), 0, 16'h2418, 0, "R3");
    step(0, 0, predCmd(2, 0, 0), 0, 16'h2418, 0, "R3");
    step(0, 0, 0, 0, 16'h2418, 0, "R3");

    // R8 and R9: back-to-back predicate then draw
    pc(2, 0, 0, "R8"); drawF(1, "R8");
    drawF(0, "R9"); drawF(1, "R9");
    pc(2, 0, 1, "R8"); drawF(0, "R9"); drawF(1, "R8");
    step(0, 0, 32'h0000_0100, 0, 16'h2418, 0, "R9");

    // R10: operand write colliding with equality command
    wr(16'h2400, 32'd9, "R10"); wr(16'h2408, 32'd4, "R10");
    wr(16'h2404, 32'd0, "R10"); wr(16'h240C, 32'd0, "R10");
    step(1, 0, predCmd(2, 0, 2), 1, 16'h2408, 32'd9, "R10");
    drawF(1, "R10"); step(0, 0, 0, 0, 16'h2408, 0, "R10");
    pc(2, 0, 0, "R10");
    step(1, 0, predCmd(2, 0, 2), 1, 16'h2408, 32'd3, "R10");
    drawF(1, "R10"); step(0, 0, 0, 0, 16'h2408, 0, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule